// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for an in-order five-stage integer pipeline with a 32-entry register file, where each of the two ALU operands of the instruction now in the execute stage should come from. It compares the two source indices of that instruction with the destination index and write flag of the two older instructions still in flight. The first older instruction has just left execute. The second is about to write back. Each operand gets its own 2-bit select. Register zero is hard-wired to zero, so no write aimed at it is ever bypassed.

The select logic is purely combinational. A thin wrapper around it applies each select to a three-way operand multiplexer. The wrapper then captures both chosen operands in an output register, which stands in for the stage register that would feed the ALU. The register file is written in the first half of a cycle and read in the second half. Because of that, a value written back in the same cycle that the register file is read needs no bypass path.

Top module: `bypass_top`

## Requirements
- R1: When the newer producer (`exm_*`) has its write flag set, a non-zero destination, and that destination equals `ex_src_a`, `sel_a` is 2'b10 and operand A takes `exm_val`.
- R2: The same rule on `ex_src_b` gives `sel_b` = 2'b10 and operand B = `exm_val`.
- R3: When the newer producer does not hit an operand, but the older producer (`mwb_*`) has its write flag set, a non-zero destination, and a destination equal to that operand's source, the select is 2'b01 and the operand takes `mwb_val`.
- R4: When both producers hit the same operand, the newer one wins: the select is 2'b10.
- R5: A source index of 0 always yields select 2'b00 and the register-file value, even if a producer names register 0 with its write flag set.
- R6: With no qualifying hit, including a matching destination whose write flag is clear, the select is 2'b00 and the operand is the register-file value (`rf_val_a` / `rf_val_b`).
- R7: Operands A and B are resolved independently, so the two selects may differ in the same cycle. The value 2'b11 never appears.
- R8: `sel_a`/`sel_b` follow the inputs in the same cycle. `opnd_a_q`/`opnd_b_q` show the chosen value one clock edge later. A synchronous active-high reset clears them to zero.
- R9: In the chain "write r2, then four consecutive readers of r2", every reader gets the new r2 value with no stall. The first reader takes it from the newer producer, the second from the older producer, and the later ones from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the operand register |
| ex_src_a | input | IDX_W | First source index of the execute-stage instruction |
| ex_src_b | input | IDX_W | Second source index of the execute-stage instruction |
| rf_val_a | input | DATA_W | Register-file value read for the first source |
| rf_val_b | input | DATA_W | Register-file value read for the second source |
| exm_wen | input | 1 | Write flag of the newer in-flight instruction |
| exm_dst | input | IDX_W | Destination index of the newer in-flight instruction |
| exm_val | input | DATA_W | ALU result of the newer in-flight instruction |
| mwb_wen | input | 1 | Write flag of the older in-flight instruction |
| mwb_dst | input | IDX_W | Destination index of the older in-flight instruction |
| mwb_val | input | DATA_W | Write-back value of the older in-flight instruction |
| sel_a | output | 2 | Operand A source: 00 register file, 10 newer, 01 older |
| sel_b | output | 2 | Operand B source, same encoding |
| opnd_a_q | output | DATA_W | Registered operand A |
| opnd_b_q | output | DATA_W | Registered operand B |

## Verification
On every cycle the assertions check the hit rules for the newer and older producers, the priority when both hit, the zero-register exclusion, the absence of the unused select code, and the fact that the registered operand carries the value its select picked on the previous edge. Some behaviour only the bench's scenarios can show. The first is that a matching destination with its write flag clear has no effect. The second is that the full write-then-read chain returns the new value in every slot, with the source moving from bypass to register file. The third is the swept agreement of both operands over every index and write-flag combination of a reduced index width.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_REGFILE = 2'b00,
    SRC_OLDER   = 2'b01,
    SRC_NEWER   = 2'b10
  } byp_src_e;
endpackage

// File: rtl/bypass_match.sv
module bypass_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic             prod_wen,
  input  logic [IDX_W-1:0] prod_dst,
  output logic             hit
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  always_comb begin
    hit = prod_wen && (prod_dst != ZERO_IDX) && (prod_dst == src_idx);
  end
endmodule

// File: rtl/bypass_select.sv
module bypass_select
  import bypass_pkg::*;
(
  input  logic     hit_newer,
  input  logic     hit_older,
  output byp_src_e src_sel
);
  always_comb begin
    if (hit_newer)      src_sel = SRC_NEWER;
    else if (hit_older) src_sel = SRC_OLDER;
    else                src_sel = SRC_REGFILE;
  end
endmodule

// File: rtl/bypass_opmux.sv
module bypass_opmux
  import bypass_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  byp_src_e    src_sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] newer_val,
  input  logic [DATA_W-1:0] older_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (src_sel)
      SRC_NEWER:   opnd = newer_val;
      SRC_OLDER:   opnd = older_val;
      default:     opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/bypass_top.sv
module bypass_top
  import bypass_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ex_src_a,
  input  logic [IDX_W-1:0]  ex_src_b,
  input  logic [DATA_W-1:0] rf_val_a,
  input  logic [DATA_W-1:0] rf_val_b,
  input  logic              exm_wen,
  input  logic [IDX_W-1:0]  exm_dst,
  input  logic [DATA_W-1:0] exm_val,
  input  logic              mwb_wen,
  input  logic [IDX_W-1:0]  mwb_dst,
  input  logic [DATA_W-1:0] mwb_val,
  output logic [SEL_W-1:0]  sel_a,
  output logic [SEL_W-1:0]  sel_b,
  output logic [DATA_W-1:0] opnd_a_q,
  output logic [DATA_W-1:0] opnd_b_q
);
  localparam int NUM_OPND = 2;

  logic [IDX_W-1:0]  src_idx [NUM_OPND];
  logic [DATA_W-1:0] rf_val  [NUM_OPND];
  byp_src_e          src_sel [NUM_OPND];
  logic [DATA_W-1:0] opnd_d  [NUM_OPND];
  logic [DATA_W-1:0] opnd_q  [NUM_OPND];

  assign src_idx[0] = ex_src_a;
  assign src_idx[1] = ex_src_b;
  assign rf_val[0]  = rf_val_a;
  assign rf_val[1]  = rf_val_b;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic hit_newer;
    logic hit_older;

    bypass_match #(.IDX_W(IDX_W)) u_match_newer (
      .src_idx  (src_idx[g]),
      .prod_wen (exm_wen),
      .prod_dst (exm_dst),
      .hit      (hit_newer)
    );

    bypass_match #(.IDX_W(IDX_W)) u_match_older (
      .src_idx  (src_idx[g]),
      .prod_wen (mwb_wen),
      .prod_dst (mwb_dst),
      .hit      (hit_older)
    );

    bypass_select u_select (
      .hit_newer (hit_newer),
      .hit_older (hit_older),
      .src_sel   (src_sel[g])
    );

    bypass_opmux #(.DATA_W(DATA_W)) u_mux (
      .src_sel   (src_sel[g]),
      .rf_val    (rf_val[g]),
      .newer_val (exm_val),
      .older_val (mwb_val),
      .opnd      (opnd_d[g])
    );

    always_ff @(posedge clk) begin
      if (rst) opnd_q[g] <= '0;
      else     opnd_q[g] <= opnd_d[g];
    end
  end

  assign sel_a    = src_sel[0];
  assign sel_b    = src_sel[1];
  assign opnd_a_q = opnd_q[0];
  assign opnd_b_q = opnd_q[1];
endmodule

// File: rtl/bypass_chk.sv
module bypass_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  ex_src_a,
  input logic [IDX_W-1:0]  ex_src_b,
  input logic [DATA_W-1:0] rf_val_a,
  input logic [DATA_W-1:0] exm_val,
  input logic              exm_wen,
  input logic [IDX_W-1:0]  exm_dst,
  input logic              mwb_wen,
  input logic [IDX_W-1:0]  mwb_dst,
  input logic [DATA_W-1:0] mwb_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] opnd_a_q
);
  logic new_a, new_b, old_a;
  assign new_a = exm_wen && (exm_dst != '0) && (exm_dst == ex_src_a);
  assign new_b = exm_wen && (exm_dst != '0) && (exm_dst == ex_src_b);
  assign old_a = mwb_wen && (mwb_dst != '0) && (mwb_dst == ex_src_a);

  AST_NEWER_A: assert property (@(posedge clk) disable iff (rst)
    new_a |-> sel_a == 2'b10); // R1
  AST_NEWER_B: assert property (@(posedge clk) disable iff (rst)
    new_b |-> sel_b == 2'b10); // R2
  AST_OLDER_A: assert property (@(posedge clk) disable iff (rst)
    (!new_a && old_a) |-> sel_a == 2'b01); // R3
  AST_BOTH_A: assert property (@(posedge clk) disable iff (rst)
    (new_a && old_a) |-> sel_a != 2'b01); // R4
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (rst)
    (ex_src_a == '0) |-> sel_a == 2'b00); // R5
  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11) && (sel_b != 2'b11)); // R7
  AST_REG_NEWER: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b10) |=> opnd_a_q == $past(exm_val)); // R8
  AST_REG_OLDER: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b01) |=> opnd_a_q == $past(mwb_val)); // R8
  AST_REG_RF: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b00) |=> opnd_a_q == $past(rf_val_a)); // R6
endmodule

bind bypass_top bypass_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .ex_src_a (ex_src_a),
  .ex_src_b (ex_src_b),
  .rf_val_a (rf_val_a),
  .exm_val  (exm_val),
  .exm_wen  (exm_wen),
  .exm_dst  (exm_dst),
  .mwb_wen  (mwb_wen),
  .mwb_dst  (mwb_dst),
  .mwb_val  (mwb_val),
  .sel_a    (sel_a),
  .sel_b    (sel_b),
  .opnd_a_q (opnd_a_q)
);

// File: tb/bypass_top_tb_top.sv
module bypass_top_tb_top;
  localparam int IW = 3;
  localparam int DW = 16;
  localparam int NREG = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IW-1:0] src_a = '0, src_b = '0, edst = '0, mdst = '0;
  logic [DW-1:0] rfa = '0, rfb = '0, ev = '0, mv = '0;
  logic ew = 1'b0, mw = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] oa, ob;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bypass_top #(.IDX_W(IW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .ex_src_a(src_a), .ex_src_b(src_b),
    .rf_val_a(rfa), .rf_val_b(rfb), .exm_wen(ew), .exm_dst(edst),
    .exm_val(ev), .mwb_wen(mw), .mwb_dst(mdst), .mwb_val(mv),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a_q(oa), .opnd_b_q(ob));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] want(input logic [IW-1:0] s);
    if (ew && edst != 0 && edst == s) return 2'b10;
    if (mw && mdst != 0 && mdst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tag_of(input logic [IW-1:0] s, input bit is_b);
    logic [1:0] w;
    w = want(s);
    if (w == 2'b10) return (mw && mdst == s) ? "R4" : (is_b ? "R2" : "R1");
    if (w == 2'b01) return "R3";
    return (s == 0) ? "R5" : "R6";
  endfunction

  // drive at negedge, check selects, then registered operands after the edge
  task automatic step(input bit check_sel);
    logic [1:0] wa, wb;
    logic [DW-1:0] va, vb;
    string ta, tb;
    #1;
    wa = want(src_a); wb = want(src_b);
    ta = tag_of(src_a, 1'b0); tb = tag_of(src_b, 1'b1);
    va = (wa == 2'b10) ? ev : (wa == 2'b01) ? mv : rfa;
    vb = (wb == 2'b10) ? ev : (wb == 2'b01) ? mv : rfb;
    if (check_sel) begin
      chk({ta, " sel_a"}, 32'(sel_a), 32'(wa));
      chk({tb, " sel_b"}, 32'(sel_b), 32'(wb));
    end
    @(posedge clk); #1;
    chk({ta, " R8 opnd_a"}, 32'(oa), 32'(va));
    chk({tb, " R8 opnd_b"}, 32'(ob), 32'(vb));
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    // R8: reset clears operand register even with live hits
    src_a = 3'd1; edst = 3'd1; ew = 1'b1; ev = 16'hBEEF; rfb = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset opnd_a", 32'(oa), 32'h0);
    chk("R8 reset opnd_b", 32'(ob), 32'h0);
    @(negedge clk); rst = 1'b0;

    // R7: independent selects
    src_a = 3'd1; src_b = 3'd2; ew = 1'b1; edst = 3'd1; mw = 1'b1; mdst = 3'd2;
    ev = 16'h1111; mv = 16'h2222; rfa = 16'hAAAA; rfb = 16'hBBBB;
    #1;
    chk("R7 sel_a", 32'(sel_a), 32'h2);
    chk("R7 sel_b", 32'(sel_b), 32'h1);
    step(1'b1);

    // R5: write to register 0 never bypassed
    src_a = 3'd0; src_b = 3'd0; ew = 1'b1; edst = 3'd0; mw = 1'b1; mdst = 3'd0;
    step(1'b1);

    // R9: r2 written, then four readers of r2
    rfa = 16'h0005; rfb = 16'h0005;           // stale r2
    src_a = 3'd1; src_b = 3'd3; ew = 1'b0; mw = 1'b0; step(1'b1); // producer in execute
    src_a = 3'd2; src_b = 3'd5; ew = 1'b1; edst = 3'd2; ev = 16'h00C7; step(1'b1);
    chk("R9 reader1 newer", 32'(oa), 32'h00C7);
    src_a = 3'd6; src_b = 3'd2; edst = 3'd4; ev = 16'h0001;
    mw = 1'b1; mdst = 3'd2; mv = 16'h00C7; step(1'b1);
    chk("R9 reader2 older", 32'(ob), 32'h00C7);
    rfa = 16'h00C7; rfb = 16'h00C7;           // written in first half-cycle
    src_a = 3'd2; src_b = 3'd2; edst = 3'd6; mdst = 3'd4; mv = 16'h0001; step(1'b1);
    chk("R9 reader3 regfile a", 32'(oa), 32'h00C7);
    chk("R9 reader3 regfile b", 32'(ob), 32'h00C7);
    src_a = 3'd2; src_b = 3'd0; ew = 1'b0; mdst = 3'd6; step(1'b1);
    chk("R9 reader4 regfile", 32'(oa), 32'h00C7);

    // sweep over all index and flag combinations (R1..R6)
    for (int a = 0; a < NREG; a++)
      for (int ed = 0; ed < NREG; ed++)
        for (int md = 0; md < NREG; md++)
          for (int fl = 0; fl < 4; fl++) begin
            src_a = IW'(a); src_b = IW'((a + ed + md + fl) % NREG);
            edst = IW'(ed); mdst = IW'(md);
            ew = fl[0]; mw = fl[1];
            rfa = DW'(16'hA000 + a * 64 + ed * 8 + md);
            rfb = DW'(16'hB000 + a * 64 + ed * 8 + md);
            ev  = DW'(16'hC000 + ed * 16 + fl);
            mv  = DW'(16'hD000 + md * 16 + fl);
            step(1'b1);
          end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule